// File: doc/BRIEF.md
# Byte-Stream CRC-16 Engine with Input Counter

This block computes a 16-bit cyclic redundancy check over a stream of bytes that software writes one at a time, for checking link frames. It sits behind a small register port. Software first clears it through a bit in its control register. It then writes each data item to the input register, and finally reads back the checksum from the result register. The engine also counts how many items it has consumed. That count is readable in the low field of the control register, so software can confirm that no write was lost.

The checksum uses the 16-bit CCITT polynomial in its bit-reflected form, 0x8408, and shifts the least significant bit first. The running state starts from zero after a clear. The result register shows that state XORed with 0xFCDE. With those constants, a clear followed by the bytes 0xCC, 0xF5, 0xF1 and 0xA7 gives a count of 4 and a result of 0x51DF. Start-up software uses this known pair as a self-test.

Top module: `crc_engine`

## Requirements
- R1: After reset the count reads 0 and the result register reads 0xFCDE, which is a zero state XORed with the output constant.
- R2: A write to the control register (address 0) with bit 15 set returns the CRC state to zero and the count to zero. The result takes effect on the next clock edge.
- R3: A write to the control register with bit 15 clear changes neither the count nor the result.
- R4: Each write to the input register (address 1) raises the count, shown in bits 11:0 of the control register, by exactly one. Bits 15:12 of the control read are zero.
- R5: Each input write folds the low 8 bits of the data into the state in one clock. The fold uses the reflected polynomial 0x8408, least significant bit first. The result register (address 2) reads the state XORed with 0xFCDE.
- R6: A clear followed by inputs 0xCC, 0xF5, 0xF1 and 0xA7 leaves the count at 4 and the result at 0x51DF.
- R7: Input bits 15:8 have no effect on the checksum. The write still counts as one item.
- R8: The count saturates at 0xFFF. A further input still updates the checksum but leaves the count at 0xFFF.
- R9: A read presented with rd_en returns its value on rd_data one clock later. A read of address 1 or 3 returns zero. A read returns state as it stood before any write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 input data |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address: 0 control/count, 2 result |
| rd_data | output | 16 | Registered read data, valid the cycle after rd_en |

## Verification
A write updates the state and the count at the clock edge where it is sampled. A read issued in the following cycle sees the update, and its data appears on rd_data one edge after the read is sampled. The reference model in the bench snapshots its expected read value at the sampling edge, before it applies that cycle's write. It compares that value with rd_data at the next falling edge, so reads and writes in the same cycle are held to the old value. The model is compared on every clock that carries a read. Runs cover the self-test vector, masked high input bits, control writes without the clear bit, and 4097 inputs to reach saturation.

// File: rtl/crc_engine_pkg.sv
package crc_engine_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL   = 2'd0,
    ADR_INPUT  = 2'd1,
    ADR_RESULT = 2'd2,
    ADR_SPARE  = 2'd3
  } crc_addr_e;

  localparam int CLEAR_BIT = 15;
endpackage

// File: rtl/crc_fold_core.sv
module crc_fold_core #(
  parameter int           CRC_W  = 16,
  parameter int           BYTE_W = 8,
  parameter logic [15:0]  POLY   = 16'h8408,
  parameter logic [15:0]  INIT   = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              push,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  state_q
);
  localparam logic [CRC_W-1:0] POLY_W = POLY[CRC_W-1:0];
  localparam logic [CRC_W-1:0] INIT_W = INIT[CRC_W-1:0];

  logic [CRC_W-1:0] stage [BYTE_W+1];

  assign stage[0] = state_q ^ {{(CRC_W-BYTE_W){1'b0}}, din};

  generate
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY_W)
                                      : (stage[i] >> 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) state_q <= INIT_W;
    else if (push)    state_q <= stage[BYTE_W];
  end

  p_clear_state_r2: assert property (@(posedge clk) disable iff (rst)
    clear |=> state_q == INIT_W);
  p_hold_state_r3: assert property (@(posedge clk) disable iff (rst)
    (!clear && !push) |=> $stable(state_q));
endmodule

// File: rtl/crc_item_counter.sv
module crc_item_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  output logic [CNT_W-1:0] count_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear)                 count_q <= '0;
    else if (push && count_q != CNT_MAX) count_q <= count_q + 1'b1;
  end

  p_clear_cnt_r2: assert property (@(posedge clk) disable iff (rst)
    clear |=> count_q == '0);
  p_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (push && !clear && count_q != CNT_MAX) |=> count_q == $past(count_q) + 1'b1);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (push && !clear && count_q == CNT_MAX) |=> count_q == CNT_MAX);
  p_hold_cnt_r3: assert property (@(posedge clk) disable iff (rst)
    (!clear && !push) |=> $stable(count_q));
endmodule

// File: rtl/crc_reg_port.sv
module crc_reg_port
  import crc_engine_pkg::*;
#(
  parameter int           CRC_W   = 16,
  parameter int           BYTE_W  = 8,
  parameter int           CNT_W   = 12,
  parameter logic [15:0]  XOR_OUT = 16'hFCDE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CRC_W-1:0]  state,
  input  logic [CNT_W-1:0]  count,
  output logic              clear,
  output logic              push,
  output logic [BYTE_W-1:0] din,
  output logic [REG_W-1:0]  rd_data
);
  logic [REG_W-1:0] rd_next;
  logic             unused_hi;

  assign clear     = wr_en && (wr_addr == ADR_CTRL) && wr_data[CLEAR_BIT];
  assign push      = wr_en && (wr_addr == ADR_INPUT);
  assign din       = wr_data[BYTE_W-1:0];
  assign unused_hi = ^wr_data[CLEAR_BIT-1:BYTE_W];

  always_comb begin
    unique case (crc_addr_e'(rd_addr))
      ADR_CTRL:   rd_next = {{(REG_W-CNT_W){1'b0}}, count};
      ADR_RESULT: rd_next = state ^ XOR_OUT[CRC_W-1:0];
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  p_rd_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_addr == ADR_INPUT || rd_addr == ADR_SPARE)) |=> rd_data == '0);
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  p_ctrl_hi_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADR_CTRL) |=> rd_data[REG_W-1:CNT_W] == '0);
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_engine_pkg::*;
#(
  parameter int           CRC_W   = 16,
  parameter int           BYTE_W  = 8,
  parameter int           CNT_W   = 12,
  parameter logic [15:0]  POLY    = 16'h8408,
  parameter logic [15:0]  INIT    = 16'h0000,
  parameter logic [15:0]  XOR_OUT = 16'hFCDE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  logic              clear;
  logic              push;
  logic [BYTE_W-1:0] din;
  logic [CRC_W-1:0]  state;
  logic [CNT_W-1:0]  count;

  crc_reg_port #(
    .CRC_W(CRC_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .XOR_OUT(XOR_OUT)
  ) u_port (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .state(state), .count(count),
    .clear(clear), .push(push), .din(din),
    .rd_data(rd_data)
  );

  crc_fold_core #(
    .CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY), .INIT(INIT)
  ) u_core (
    .clk(clk), .rst(rst), .clear(clear), .push(push), .din(din),
    .state_q(state)
  );

  crc_item_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .clear(clear), .push(push), .count_q(count)
  );

  p_one_action_r2: assert property (@(posedge clk) disable iff (rst)
    !(clear && push));
endmodule

// File: tb/crc_engine_tb.sv
module crc_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int total = 0;
  int bad   = 0;
  string cur_tag = "R9";

  crc_engine u_dut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  // Reference model: plain integers, serial bitwise fold
  int          m_cnt = 0;
  logic [15:0] m_crc = 16'h0000;
  logic [15:0] exp_rd = 16'h0000;
  bit          exp_valid = 1'b0;
  string       exp_tag = "R9";

  function automatic logic [15:0] fold(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x;
    x = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++)
      x = x[0] ? ((x >> 1) ^ 16'h8408) : (x >> 1);
    return x;
  endfunction

  always @(posedge clk) begin
    exp_valid = 1'b0;
    if (rst) begin
      m_cnt = 0;
      m_crc = 16'h0000;
      exp_rd = 16'h0000;
    end else begin
      if (rd_en) begin
        exp_valid = 1'b1;
        exp_tag = cur_tag;
        case (rd_addr)
          2'd0:    exp_rd = 16'(m_cnt);
          2'd2:    exp_rd = m_crc ^ 16'hFCDE;
          default: exp_rd = 16'h0000;
        endcase
      end
      if (wr_en && wr_addr == 2'd0 && wr_data[15]) begin
        m_cnt = 0;
        m_crc = 16'h0000;
      end else if (wr_en && wr_addr == 2'd1) begin
        m_crc = fold(m_crc, wr_data[7:0]);
        if (m_cnt < 4095) m_cnt = m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (exp_valid) begin
      total++;
      if (rd_data !== exp_rd) begin
        bad++;
        $display("FAIL %s: rd_data=%h expected=%h", exp_tag, rd_data, exp_rd);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    rd_en = 1'b1; rd_addr = a; cur_tag = tag;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_now(input logic [15:0] want, input string tag);
    total++;
    if (rd_data !== want) begin
      bad++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, want);
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, "R1"); expect_now(16'h0000, "R1");
    rd(2'd2, "R1"); expect_now(16'hFCDE, "R1");

    // R6 check vector, and R2 clear
    wr(2'd1, 16'h0012);
    wr(2'd0, 16'h8000);
    rd(2'd0, "R2"); expect_now(16'h0000, "R2");
    wr(2'd1, 16'h00CC);
    wr(2'd1, 16'h00F5);
    wr(2'd1, 16'h00F1);
    wr(2'd1, 16'h00A7);
    rd(2'd0, "R6"); expect_now(16'h0004, "R6");
    rd(2'd2, "R6"); expect_now(16'h51DF, "R6");

    // R3 control write without clear bit
    wr(2'd0, 16'h7FFF);
    rd(2'd0, "R3"); expect_now(16'h0004, "R3");
    rd(2'd2, "R3"); expect_now(16'h51DF, "R3");

    // R7 high bits ignored: same vector with junk in bits 15:8
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'hFECC);
    wr(2'd1, 16'h0AF5);
    wr(2'd1, 16'h81F1);
    wr(2'd1, 16'h3CA7);
    rd(2'd2, "R7"); expect_now(16'h51DF, "R7");
    rd(2'd0, "R7"); expect_now(16'h0004, "R7");

    // R5 various patterns, R4 count steps
    for (int i = 0; i < 20; i++) begin
      wr(2'd1, 16'(i * 37 + 5));
      rd(2'd2, "R5");
      rd(2'd0, "R4");
    end

    // R9 zero addresses and same-cycle read/write
    rd(2'd1, "R9");
    rd(2'd3, "R9");
    rd_en = 1'b1; rd_addr = 2'd0; cur_tag = "R9";
    wr(2'd1, 16'h0055);
    rd_en = 1'b0;
    rd(2'd0, "R9");

    // R8 saturation
    wr(2'd0, 16'h8000);
    for (int i = 0; i < 4095; i++) wr(2'd1, 16'(i));
    rd(2'd0, "R8"); expect_now(16'h0FFF, "R8");
    wr(2'd1, 16'h00AB);
    wr(2'd1, 16'h00CD);
    rd(2'd0, "R8"); expect_now(16'h0FFF, "R8");
    rd(2'd2, "R8");

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule